// File: doc/BRIEF.md
# Multi-Channel Periodic Tick Timer

This block holds a small set of independent countdown channels that share one tick-enable input. Each channel keeps a reload value and a down-counter. When a running channel's counter is at zero on a tick, the channel raises its time-out flag and starts a new period from the reload value. A period is therefore reload+1 ticks. Software can also reload chosen counters at any time through a write-one register. The flags combine with per-channel interrupt enables into a single interrupt line.

A channel runs only while its own enable and the block-wide enable are both set. The counter is loaded from the reload register on the clock after the channel starts running, whether its enable or the block enable was the last to be set. Clearing the block enable freezes every counter and leaves the flags as they are. Clearing a channel enable stops that channel and drops its flag in the same write.

All registers sit on a plain bus: address, write data, write strobe and registered read data. Read data appears on the clock after the address is presented.

Top module: `periodic_tick_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low. Register map: 0 = block enable (bit 0), 1 = channel enables (bits 3:0), 2 = force-reload (bits 3:0), 3 = time-out flags (bits 3:0), 4 = interrupt enables (bits 3:0), 8+n = reload value of channel n, 12+n = current count of channel n (read-only). Read data is registered and reflects the addressed state one clock after the address is applied.
- R2: When a channel becomes running (channel enable and block enable both set), its counter is loaded from its reload register on the following clock.
- R3: A running channel whose counter is zero on a tick sets its flag and reloads, so the flag recurs every reload+1 ticks.
- R4: Writing a one to a force-reload bit of a running channel copies that channel's reload value into its counter. Bits written as zero have no effect.
- R5: A force-reload write to a channel that is disabled, or written while the block enable is clear, leaves the counter unchanged.
- R6: The force-reload register always reads zero. Bits 15:4 of the channel-enable register are not stored and read as zero.
- R7: Writing a zero to a channel enable bit clears that channel's flag in the same write and stops its counter.
- R8: Flags are write-one-to-clear. A zero written to a flag bit leaves that flag unchanged.
- R9: `irq` is high one clock after any flag is set together with its interrupt-enable bit, and low one clock after no such pair remains.
- R10: Clearing the block enable freezes all counters and keeps the flags. Setting it again reloads every enabled channel's counter.
- R11: If a force-reload and an underflow fall on the same clock, the counter takes the reload value and the flag is not set.
- R12: Counters change only on clocks where `tick` is high, apart from the loads in R2, R4 and R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable shared by all channels |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe, one clock per write |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
On every clock the assertions check several rules. A channel with its enable clear never shows a flag. A counter that is not running, or that sees no tick and no load, holds its value. Underflow and forced loads land on the reload value, and a forced load never sets a flag. The force register reads zero, and a quiet flag/enable set keeps `irq` low. The bench scenarios cover the rest: exact period length, the write-one-to-clear and reserved-bit behaviour at the bus, freezing and reloading around the block enable, the priority of a forced load over an underflow on the same tick, and the one-clock latency of `irq`.

// File: rtl/ptt_pkg.sv
package ptt_pkg;

  // control register offsets
  localparam int unsigned A_CTRL  = 0;
  localparam int unsigned A_CHEN  = 1;
  localparam int unsigned A_FORCE = 2;
  localparam int unsigned A_FLAGS = 3;
  localparam int unsigned A_IRQEN = 4;

  // first reload register; count registers follow the reload block
  localparam int unsigned LOAD_BASE = 8;

  // per-channel control produced by the register bank
  typedef struct packed {
    logic run;      // channel enable and block enable both set
    logic ch_en;    // channel enable bit alone
    logic force_ld; // accepted force-reload write
    logic w1c;      // flag clear by write-one
    logic dis_clr;  // channel enable written to zero
  } ch_ctl_t;

endpackage

// File: rtl/ptt_regs.sv
module ptt_regs
  import ptt_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic                      wr_en,
  input  logic [NUM_CH-1:0]         flags,
  input  logic [NUM_CH*CNT_W-1:0]   counts,
  output ch_ctl_t [NUM_CH-1:0]      ctl,
  output logic [NUM_CH*CNT_W-1:0]   load_vals,
  output logic [NUM_CH-1:0]         irq_en,
  output logic [DATA_W-1:0]         rd_data
);

  localparam int unsigned CNT_BASE = LOAD_BASE + NUM_CH;

  logic                 mod_en_q;
  logic [NUM_CH-1:0]    ch_en_q;
  logic [NUM_CH-1:0]    irq_en_q;
  logic [CNT_W-1:0]     ld_q [NUM_CH];
  logic [DATA_W-1:0]    rd_next;

  logic wr_ctrl, wr_chen, wr_force, wr_flags, wr_irqen;

  assign wr_ctrl  = wr_en && (addr == ADDR_W'(A_CTRL));
  assign wr_chen  = wr_en && (addr == ADDR_W'(A_CHEN));
  assign wr_force = wr_en && (addr == ADDR_W'(A_FORCE));
  assign wr_flags = wr_en && (addr == ADDR_W'(A_FLAGS));
  assign wr_irqen = wr_en && (addr == ADDR_W'(A_IRQEN));

  // control state
  always_ff @(posedge clk) begin
    if (rst) begin
      mod_en_q <= 1'b0;
      ch_en_q  <= '0;
      irq_en_q <= '0;
    end else begin
      if (wr_ctrl)  mod_en_q <= wdata[0];
      if (wr_chen)  ch_en_q  <= wdata[NUM_CH-1:0];
      if (wr_irqen) irq_en_q <= wdata[NUM_CH-1:0];
    end
  end

  // reload registers, one write port, no reset needed beyond zeroing
  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ld
      always_ff @(posedge clk) begin
        if (rst)
          ld_q[g] <= '0;
        else if (wr_en && (addr == ADDR_W'(LOAD_BASE + g)))
          ld_q[g] <= wdata[CNT_W-1:0];
      end
      assign load_vals[g*CNT_W +: CNT_W] = ld_q[g];

      assign ctl[g].run      = mod_en_q & ch_en_q[g];
      assign ctl[g].ch_en    = ch_en_q[g];
      assign ctl[g].force_ld = wr_force & wdata[g] & mod_en_q & ch_en_q[g];
      assign ctl[g].w1c      = wr_flags & wdata[g];
      assign ctl[g].dis_clr  = wr_chen & ~wdata[g];
    end
  endgenerate

  assign irq_en = irq_en_q;

  // read mux; force register and reserved bits fall through as zero
  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(A_CTRL))  rd_next[0] = mod_en_q;
    if (addr == ADDR_W'(A_CHEN))  rd_next[NUM_CH-1:0] = ch_en_q;
    if (addr == ADDR_W'(A_FLAGS)) rd_next[NUM_CH-1:0] = flags;
    if (addr == ADDR_W'(A_IRQEN)) rd_next[NUM_CH-1:0] = irq_en_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(LOAD_BASE + i)) rd_next[CNT_W-1:0] = ld_q[i];
      if (addr == ADDR_W'(CNT_BASE + i))  rd_next[CNT_W-1:0] = counts[i*CNT_W +: CNT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  AST_FORCE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(A_FORCE)) |=> (rd_data == '0)); // R6

  AST_CHEN_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(A_CHEN)) |=> (rd_data[DATA_W-1:NUM_CH] == '0)); // R6

endmodule

// File: rtl/ptt_channel.sv
module ptt_channel
  import ptt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  ch_ctl_t          ctl,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);

  logic             run_q;
  logic             start;
  logic             reload;
  logic             underflow;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;

  assign start     = ctl.run & ~run_q;
  assign reload    = start | ctl.force_ld;
  assign underflow = ctl.run & tick & ~reload & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= ctl.run;
      if (reload || underflow)
        cnt_q <= load_val;
      else if (ctl.run && tick)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  // disable clear beats a new time-out, which beats a write-one clear
  always_ff @(posedge clk) begin
    if (rst)              flag_q <= 1'b0;
    else if (ctl.dis_clr) flag_q <= 1'b0;
    else if (underflow)   flag_q <= 1'b1;
    else if (ctl.w1c)     flag_q <= 1'b0;
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;

  AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    !ctl.ch_en |-> !flag_q); // R7

  AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ctl.run |=> $stable(cnt_q)); // R10

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ctl.run && run_q && !tick && !ctl.force_ld) |=> $stable(cnt_q)); // R12

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (ctl.run && run_q && tick && !ctl.force_ld && cnt_q == '0 && !ctl.dis_clr)
      |=> (cnt_q == $past(load_val)) && flag_q); // R3

  AST_FORCE_WINS: assert property (@(posedge clk) disable iff (rst)
    (ctl.force_ld && !flag_q) |=> (cnt_q == $past(load_val)) && !flag_q); // R11

endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer
  import ptt_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  ch_ctl_t [NUM_CH-1:0]     ctl;
  logic [NUM_CH*CNT_W-1:0]  load_vals;
  logic [NUM_CH*CNT_W-1:0]  counts;
  logic [NUM_CH-1:0]        flags;
  logic [NUM_CH-1:0]        irq_en;
  logic                     irq_q;

  ptt_regs #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .wdata     (wdata),
    .wr_en     (wr_en),
    .flags     (flags),
    .counts    (counts),
    .ctl       (ctl),
    .load_vals (load_vals),
    .irq_en    (irq_en),
    .rd_data   (rd_data)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      ptt_channel #(
        .CNT_W (CNT_W)
      ) u_ch (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .ctl      (ctl[g]),
        .load_val (load_vals[g*CNT_W +: CNT_W]),
        .cnt      (counts[g*CNT_W +: CNT_W]),
        .flag     (flags[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags & irq_en);
  end

  assign irq = irq_q;

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((flags & irq_en) == '0) |=> !irq_q); // R9

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    ((flags & irq_en) != '0) |=> irq_q); // R9

endmodule

// File: tb/periodic_tick_timer_tb.sv
module periodic_tick_timer_tb;

  localparam int unsigned AW = 4;
  localparam int unsigned DW = 16;

  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_TK = 2'd2;

  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    '{OP_WR, 4'd8,  16'd3,      4'd2},  // R2 reload ch0 = 3
    '{OP_WR, 4'd0,  16'd1,      4'd2},  // R2 block enable
    '{OP_WR, 4'd1,  16'd1,      4'd2},  // R2 enable ch0
    '{OP_RD, 4'd12, 16'd3,      4'd2},  // R2 counter loaded
    '{OP_TK, 4'd0,  16'd2,      4'd12}, // R12 two ticks
    '{OP_RD, 4'd12, 16'd1,      4'd12}, // R12 only ticks move it
    '{OP_TK, 4'd0,  16'd1,      4'd3},  // R3
    '{OP_RD, 4'd3,  16'd0,      4'd3},  // R3 at zero, no flag yet
    '{OP_TK, 4'd0,  16'd1,      4'd3},  // R3 underflow tick
    '{OP_RD, 4'd3,  16'd1,      4'd3},  // R3 flag set
    '{OP_RD, 4'd12, 16'd3,      4'd3},  // R3 reloaded
    '{OP_WR, 4'd3,  16'd0,      4'd8},  // R8 zero write
    '{OP_RD, 4'd3,  16'd1,      4'd8},  // R8 flag kept
    '{OP_WR, 4'd3,  16'd1,      4'd8},  // R8 one write
    '{OP_RD, 4'd3,  16'd0,      4'd8},  // R8 flag cleared
    '{OP_TK, 4'd0,  16'd2,      4'd4},  // R4 count to 1
    '{OP_WR, 4'd2,  16'd0,      4'd4},  // R4 zero force
    '{OP_RD, 4'd12, 16'd1,      4'd4},  // R4 no effect
    '{OP_WR, 4'd2,  16'd1,      4'd4},  // R4 force ch0
    '{OP_RD, 4'd12, 16'd3,      4'd4},  // R4 reloaded
    '{OP_RD, 4'd2,  16'd0,      4'd6},  // R6 force reads zero
    '{OP_WR, 4'd9,  16'd5,      4'd5},  // R5 reload ch1 = 5
    '{OP_WR, 4'd2,  16'd2,      4'd5},  // R5 force disabled ch1
    '{OP_RD, 4'd13, 16'd0,      4'd5},  // R5 unchanged
    '{OP_WR, 4'd1,  16'hFFF3,   4'd6},  // R6 reserved bits set
    '{OP_RD, 4'd1,  16'd3,      4'd6},  // R6 read as zero
    '{OP_RD, 4'd13, 16'd5,      4'd2},  // R2 ch1 loaded
    '{OP_TK, 4'd0,  16'd1,      4'd10}, // R10 one tick
    '{OP_WR, 4'd0,  16'd0,      4'd10}, // R10 block off
    '{OP_TK, 4'd0,  16'd3,      4'd10}, // R10 ticks while frozen
    '{OP_RD, 4'd12, 16'd2,      4'd10}, // R10 ch0 frozen
    '{OP_RD, 4'd13, 16'd4,      4'd10}, // R10 ch1 frozen
    '{OP_WR, 4'd2,  16'd3,      4'd5},  // R5 force with block off
    '{OP_RD, 4'd13, 16'd4,      4'd5},  // R5 unchanged
    '{OP_WR, 4'd0,  16'd1,      4'd10}, // R10 block on again
    '{OP_RD, 4'd12, 16'd3,      4'd10}, // R10 ch0 reloaded
    '{OP_RD, 4'd13, 16'd5,      4'd10}  // R10 ch1 reloaded
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic          irq;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  periodic_tick_timer u_dut (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .addr    (addr),
    .wdata   (wdata),
    .wr_en   (wr_en),
    .rd_data (rd_data),
    .irq     (irq)
  );

  task automatic check(input int req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic tk);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; tick = tk;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a;
    @(posedge clk);
    @(posedge clk);
    #1 d = rd_data;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic rd_chk(input int req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] v;
    bus_rd(a, v);
    check(req, v, exp);
  endtask

  task automatic irq_chk(input int req, input logic exp);
    repeat (2) @(posedge clk);
    #1 check(req, {15'd0, irq}, {15'd0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state of every register and irq
    foreach (VECS[k]) begin end
    for (int a = 0; a < 16; a++) begin
      if (a < 5 || a > 7) rd_chk(1, AW'(a), '0);
    end
    #1 check(1, {15'd0, irq}, 16'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR:   bus_wr(VECS[i].addr, VECS[i].data, 1'b0);
        OP_RD:   rd_chk(int'(VECS[i].req), VECS[i].addr, VECS[i].data);
        default: ticks(int'(VECS[i].data));
      endcase
    end

    // R11: force-reload on the same tick as an underflow
    ticks(3);                      // ch0 -> 0, ch1 -> 2
    bus_wr(4'd2, 16'd1, 1'b1);     // force ch0 with tick high
    rd_chk(11, 4'd12, 16'd3);
    rd_chk(11, 4'd3, 16'd0);
    rd_chk(12, 4'd13, 16'd1);      // R12 tick on that clock still counted ch1

    // R9: interrupt gating
    ticks(1);                      // ch1 -> 0
    ticks(1);                      // ch1 underflow, flag bit 1
    rd_chk(3, 4'd3, 16'd2);
    irq_chk(9, 1'b0);              // R9 flag without enable
    bus_wr(4'd4, 16'd2, 1'b0);
    irq_chk(9, 1'b1);              // R9 enabled flag
    bus_wr(4'd4, 16'd1, 1'b0);
    irq_chk(9, 1'b0);              // R9 enable moved to quiet channel

    // R10: block disable keeps flags
    bus_wr(4'd0, 16'd0, 1'b0);
    rd_chk(10, 4'd3, 16'd2);
    bus_wr(4'd0, 16'd1, 1'b0);

    // R7: channel disable clears its flag and stops it
    bus_wr(4'd1, 16'd1, 1'b0);
    rd_chk(7, 4'd3, 16'd0);
    ticks(2);
    rd_chk(7, 4'd13, 16'd5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule